// File: doc/BRIEF.md
# Serial Divider Programming Port

This block receives control words for a frequency synthesizer's two programmable dividers over a three-wire serial link. The three pins are a serial clock, a data line and a load strobe. Each word is 17 bits long and is sent most significant bit first. On a rising edge of the load strobe, the last bit received decides which of two holding registers takes the word.

The two holding registers lay their fields out differently. The loop divider register holds an 11-bit main count and a 5-bit swallow count. The total loop ratio is 32 times the main count plus the swallow count. The reference register holds a 13-bit reference count, an unlock-indicator enable and two test bits. The reference count sits behind a fixed divide-by-8 stage, so the total reference ratio is 8 times that count.

A one-cycle update pulse per register tells the dividers that new settings are ready. Both held settings survive standby. When standby ends, both update pulses fire so that the dividers, which were reset, reload. All three serial pins and the standby pin are brought into the system clock domain before use.

Top module: `divprog_serial`

## Requirements
- R1: After synchronous reset every held field is zero and both update pulses are low.
- R2: Each rising edge of the serial clock while the load pin is low shifts the data pin into the frame; the first bit sent becomes frame bit 1 (most significant) and the seventeenth becomes bit 17.
- R3: A load with bit 17 = 0 sets the main count from bits 1..11 (bit 1 its MSB) and the swallow count from bits 12..16 (bit 12 its MSB); frame 00100111010001000 gives main 314, swallow 4.
- R4: A load with bit 17 = 1 sets the reference count from bits 1..13 (bit 1 its MSB), the unlock enable from bit 14 and the test bits from bits 15..16; frame 00000110000001001 gives reference 192, unlock enable 1, test 0.
- R5: A load changes only the register selected by bit 17; the other keeps its value.
- R6: While the load pin is high, serial clock edges and data are ignored, so the frame is unchanged when the load pin next rises.
- R7: When more than 17 bits are clocked in before a load, only the 17 most recent bits are used.
- R8: Each load rising edge gives exactly one single-cycle pulse on the update output of the selected register, and a held-high load pin gives no further pulses.
- R9: Standby leaves all held fields unchanged; leaving standby pulses both update outputs once.
- R10: The loop ratio output equals 32 x main + swallow, and the reference ratio output equals 8 x reference count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| standby | input | 1 | Power-save request, high = standby |
| ser_clk | input | 1 | Serial bit clock pin |
| ser_data | input | 1 | Serial data pin |
| ser_le | input | 1 | Serial load strobe pin |
| main_cnt | output | 11 | Held main count |
| swal_cnt | output | 5 | Held swallow count |
| ref_cnt | output | 13 | Held reference count |
| unlock_en | output | 1 | Held unlock-indicator enable |
| test_bits | output | 2 | Held test bits |
| n_ratio | output | 16 | Total loop division ratio |
| r_ratio | output | 16 | Total reference division ratio |
| upd_main | output | 1 | Pulse: loop divider settings updated |
| upd_ref | output | 1 | Pulse: reference settings updated |

## Verification
The assertions assume that the serial pins change slowly compared with the system clock. A serial clock edge never arrives in the same synchronized cycle as a load edge, and the end of standby never comes within a cycle of a load. The stimulus holds every serial pin level for four system clocks. It waits at least ten cycles after each load or standby change before starting anything else. This keeps every edge detected exactly once and keeps the update pulses apart.

// File: rtl/divprog_pkg.sv
package divprog_pkg;

    localparam int MAIN_W    = 11;
    localparam int SWAL_W    = 5;
    localparam int REF_W     = 13;
    localparam int TEST_W    = 2;
    localparam int PRE_SHIFT = 3;

    localparam int N_PAY_W  = MAIN_W + SWAL_W;
    localparam int R_PAY_W  = REF_W + 1 + TEST_W;
    localparam int PAY_W    = (N_PAY_W > R_PAY_W) ? N_PAY_W : R_PAY_W;
    localparam int FRAME_W  = PAY_W + 1;
    localparam int N_RAT_W  = MAIN_W + SWAL_W;
    localparam int R_RAT_W  = REF_W + PRE_SHIFT;
    localparam int RATIO_W  = (N_RAT_W > R_RAT_W) ? N_RAT_W : R_RAT_W;

    typedef enum logic {
        SEL_LOOP = 1'b0,
        SEL_REF  = 1'b1
    } sel_e;

    typedef struct packed {
        logic [MAIN_W-1:0] main;
        logic [SWAL_W-1:0] swal;
    } nset_t;

    typedef struct packed {
        logic [REF_W-1:0]  rcnt;
        logic              ulk_en;
        logic [TEST_W-1:0] test;
    } rset_t;

    typedef logic [FRAME_W-1:0] frame_t;

    function automatic sel_e frame_sel(frame_t f);
        return sel_e'(f[0]);
    endfunction

    function automatic nset_t decode_loop(frame_t f);
        return nset_t'(f[FRAME_W-1 -: N_PAY_W]);
    endfunction

    function automatic rset_t decode_ref(frame_t f);
        return rset_t'(f[FRAME_W-1 -: R_PAY_W]);
    endfunction

    function automatic logic [RATIO_W-1:0] loop_ratio(nset_t n);
        logic [RATIO_W-1:0] r;
        r = RATIO_W'(n.main) << SWAL_W;
        r = r + RATIO_W'(n.swal);
        return r;
    endfunction

    function automatic logic [RATIO_W-1:0] ref_ratio(rset_t s);
        return RATIO_W'(s.rcnt) << PRE_SHIFT;
    endfunction

endpackage

// File: rtl/divprog_sync.sv
module divprog_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) stg <= '0;
                else     stg[0] <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) stg <= '0;
                else     stg <= {stg[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/divprog_shifter.sv
module divprog_shifter
    import divprog_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   shift_en,
    input  logic   bit_in,
    output frame_t frame
);
    always_ff @(posedge clk) begin
        if (rst)           frame <= '0;
        else if (shift_en) frame <= {frame[FRAME_W-2:0], bit_in};
    end
endmodule

// File: rtl/divprog_latches.sv
module divprog_latches
    import divprog_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  logic   reload,
    input  frame_t frame,
    output nset_t  nset,
    output rset_t  rset,
    output logic   upd_n,
    output logic   upd_r
);
    sel_e sel;
    logic ld_n, ld_r;

    always_comb begin
        sel  = frame_sel(frame);
        ld_n = load && (sel == SEL_LOOP);
        ld_r = load && (sel == SEL_REF);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nset  <= '0;
            rset  <= '0;
            upd_n <= 1'b0;
            upd_r <= 1'b0;
        end else begin
            if (ld_n) nset <= decode_loop(frame);
            if (ld_r) rset <= decode_ref(frame);
            upd_n <= ld_n || reload;
            upd_r <= ld_r || reload;
        end
    end
endmodule

// File: rtl/divprog_serial.sv
module divprog_serial
    import divprog_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                standby,
    input  logic                ser_clk,
    input  logic                ser_data,
    input  logic                ser_le,
    output logic [MAIN_W-1:0]   main_cnt,
    output logic [SWAL_W-1:0]   swal_cnt,
    output logic [REF_W-1:0]    ref_cnt,
    output logic                unlock_en,
    output logic [TEST_W-1:0]   test_bits,
    output logic [RATIO_W-1:0]  n_ratio,
    output logic [RATIO_W-1:0]  r_ratio,
    output logic                upd_main,
    output logic                upd_ref
);
    localparam int PIN_N = 4;

    logic [PIN_N-1:0] pins_s;
    logic s_stby, s_le, s_data, s_clk;
    logic p_stby, p_le, p_clk;
    logic clk_rise, le_rise, stby_fall, shift_en;
    frame_t frame;
    nset_t  nset;
    rset_t  rset;

    divprog_sync #(.W(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({standby, ser_le, ser_data, ser_clk}),
        .q   (pins_s)
    );

    assign {s_stby, s_le, s_data, s_clk} = pins_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            p_stby <= 1'b0;
            p_le   <= 1'b0;
            p_clk  <= 1'b0;
        end else begin
            p_stby <= s_stby;
            p_le   <= s_le;
            p_clk  <= s_clk;
        end
    end

    always_comb begin
        clk_rise  = s_clk && !p_clk;
        le_rise   = s_le && !p_le;
        stby_fall = !s_stby && p_stby;
        shift_en  = clk_rise && !s_le;
    end

    divprog_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .bit_in   (s_data),
        .frame    (frame)
    );

    divprog_latches u_latch (
        .clk    (clk),
        .rst    (rst),
        .load   (le_rise),
        .reload (stby_fall),
        .frame  (frame),
        .nset   (nset),
        .rset   (rset),
        .upd_n  (upd_main),
        .upd_r  (upd_ref)
    );

    always_comb begin
        main_cnt  = nset.main;
        swal_cnt  = nset.swal;
        ref_cnt   = rset.rcnt;
        unlock_en = rset.ulk_en;
        test_bits = rset.test;
        n_ratio   = loop_ratio(nset);
        r_ratio   = ref_ratio(rset);
    end
endmodule

// File: rtl/divprog_serial_chk.sv
module divprog_serial_chk
    import divprog_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   s_le,
    input logic   s_stby,
    input frame_t frame,
    input nset_t  nset,
    input rset_t  rset,
    input logic   upd_main,
    input logic   upd_ref
);
    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (nset == '0 && rset == '0 && !upd_main && !upd_ref));

    // R5, R8
    a_r5_loop_change_flagged: assert property (@(posedge clk) disable iff (rst)
        !$stable(nset) |-> upd_main);

    // R5, R8
    a_r5_ref_change_flagged: assert property (@(posedge clk) disable iff (rst)
        !$stable(rset) |-> upd_ref);

    // R6
    a_r6_frame_frozen: assert property (@(posedge clk) disable iff (rst)
        s_le |=> $stable(frame));

    // R9
    a_r9_wake_reload: assert property (@(posedge clk) disable iff (rst)
        $fell(s_stby) |=> (upd_main && upd_ref));
endmodule

bind divprog_serial divprog_serial_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .s_le     (s_le),
    .s_stby   (s_stby),
    .frame    (frame),
    .nset     (nset),
    .rset     (rset),
    .upd_main (upd_main),
    .upd_ref  (upd_ref)
);

// File: tb/divprog_serial_tb_top.sv
`timescale 1ns/1ps
module divprog_serial_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic standby = 1'b0, ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
    logic [10:0] main_cnt;
    logic [4:0]  swal_cnt;
    logic [12:0] ref_cnt;
    logic        unlock_en;
    logic [1:0]  test_bits;
    logic [15:0] n_ratio, r_ratio;
    logic        upd_main, upd_ref;

    int checks = 0, fails = 0;
    int cnt_main = 0, cnt_ref = 0;
    int wide_main = 0, wide_ref = 0;
    int run_main = 0, run_ref = 0;
    bit done = 0;

    always #5 clk = ~clk;

    divprog_serial dut_i (
        .clk(clk), .rst(rst), .standby(standby),
        .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
        .main_cnt(main_cnt), .swal_cnt(swal_cnt), .ref_cnt(ref_cnt),
        .unlock_en(unlock_en), .test_bits(test_bits),
        .n_ratio(n_ratio), .r_ratio(r_ratio),
        .upd_main(upd_main), .upd_ref(upd_ref)
    );

    always @(negedge clk) begin
        if (upd_main) begin
            cnt_main++;
            run_main++;
            if (run_main > 1) wide_main++;
        end else run_main = 0;
        if (upd_ref) begin
            cnt_ref++;
            run_ref++;
            if (run_ref > 1) wide_ref++;
        end else run_ref = 0;
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic waitc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_bits(logic [31:0] bits, int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = bits[i];
            waitc(4);
            ser_clk = 1'b1;
            waitc(4);
            ser_clk = 1'b0;
        end
        ser_data = 1'b0;
        waitc(4);
    endtask

    task automatic pulse_le();
        ser_le = 1'b1;
        waitc(12);
        ser_le = 1'b0;
        waitc(6);
    endtask

    task automatic clear_counts();
        cnt_main = 0;
        cnt_ref  = 0;
    endtask

    task automatic t_reset();
        check("R1 main", main_cnt, 0);
        check("R1 swal", swal_cnt, 0);
        check("R1 ref", ref_cnt, 0);
        check("R1 ulk", unlock_en, 0);
        check("R1 upd pulses", cnt_main + cnt_ref, 0);
    endtask

    task automatic t_loop_frame();
        clear_counts();
        send_bits(32'b00100111010001000, 17);
        pulse_le();
        check("R2 R3 main", main_cnt, 314);
        check("R3 swal", swal_cnt, 4);
        check("R10 n_ratio", n_ratio, 10052);
        check("R5 ref untouched", ref_cnt, 0);
        check("R8 loop pulse count", cnt_main, 1);
        check("R8 no ref pulse", cnt_ref, 0);
    endtask

    task automatic t_ref_frame();
        clear_counts();
        send_bits(32'b00000110000001001, 17);
        pulse_le();
        check("R4 ref", ref_cnt, 192);
        check("R4 ulk", unlock_en, 1);
        check("R4 test", test_bits, 0);
        check("R10 r_ratio", r_ratio, 1536);
        check("R5 main kept", main_cnt, 314);
        check("R5 swal kept", swal_cnt, 4);
        check("R8 ref pulse count", cnt_ref, 1);
        check("R8 no loop pulse", cnt_main, 0);
    endtask

    task automatic t_le_high_ignored();
        clear_counts();
        ser_le = 1'b1;
        waitc(8);
        send_bits(32'b11111111111111110, 17);
        ser_le = 1'b0;
        waitc(6);
        check("R8 held load no pulse", cnt_main + cnt_ref, 1);
        pulse_le();
        check("R6 ref same", ref_cnt, 192);
        check("R6 main same", main_cnt, 314);
        check("R6 reload ref pulses", cnt_ref, 2);
        check("R6 no loop pulse", cnt_main, 0);
    endtask

    task automatic t_overlong();
        clear_counts();
        send_bits(32'b10110, 5);
        send_bits(32'b11111111111000110, 17);
        pulse_le();
        check("R7 main", main_cnt, 2047);
        check("R7 swal", swal_cnt, 3);
        check("R10 n_ratio max", n_ratio, 65507);
        check("R7 ref kept", ref_cnt, 192);
    endtask

    task automatic t_ref_max_test();
        clear_counts();
        send_bits(32'b11111111111110111, 17);
        pulse_le();
        check("R4 ref max", ref_cnt, 8191);
        check("R4 ulk off", unlock_en, 0);
        check("R4 test bits", test_bits, 3);
        check("R10 r_ratio max", r_ratio, 65528);
    endtask

    task automatic t_standby();
        standby = 1'b1;
        waitc(10);
        clear_counts();
        check("R9 main held", main_cnt, 2047);
        check("R9 ref held", ref_cnt, 8191);
        standby = 1'b0;
        waitc(10);
        check("R9 wake loop pulse", cnt_main, 1);
        check("R9 wake ref pulse", cnt_ref, 1);
        check("R9 swal held", swal_cnt, 3);
        check("R9 test held", test_bits, 3);
    endtask

    initial begin
        waitc(4);
        rst = 1'b0;
        waitc(3);
        t_reset();
        t_loop_frame();
        t_ref_frame();
        t_le_high_ignored();
        t_overlong();
        t_ref_max_test();
        t_standby();
        check("R8 single-cycle pulses", wide_main + wide_ref, 0);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule